// File: doc/BRIEF.md
# Asynchronous Byte Slave Port

This block lets an external bus master exchange bytes with a local processor through one shared byte-wide pin group. The master drives three active-low inputs: a select, a read strobe and a write strobe. It needs no clock of its own. Inside the block there are two separate data latches. The output latch is loaded by the core and driven onto the pins during external reads. The input latch is filled by external writes and read by the core. Both sit behind one logical address.

The strobes and the pin data pass through multi-flop synchronizers into the core clock domain. The end of a transaction is detected as the synchronized strobe condition going inactive. The block keeps four flags for the core: input-full, output-full, overflow and a transaction interrupt flag. The interrupt request is the interrupt flag masked by an enable. A port-mode enable turns the whole port on or off. Pin tri-state control is a plain output-enable signal.

Top module: `byte_slave_port`

## Requirements
- R1: After reset, inFull, outFull, ovf, irqFlag, irqReq and busOe are all 0.
- R2: busOe is 1 exactly when portEn is 1 and csN and rdN are both 0, with no clock delay. busDout always shows the output latch.
- R3: An external write is active while csN and wrN are both 0. When either one returns high, the block captures the byte that was on busDin at the last synchronized sample of the active write into the input latch (coreRdData). inFull and irqFlag go to 1 on the third rising clock edge after the release, and not before.
- R4: If an external write completes while inFull is still 1, ovf becomes 1 and the new byte replaces the old one.
- R5: A coreRdIn pulse clears inFull at the next edge and leaves ovf unchanged. Only a coreOvfClr pulse clears ovf.
- R6: A coreWrOut pulse loads coreWrData into the output latch and sets outFull at the next edge, provided no synchronized read is active.
- R7: While a synchronized external read (csN and rdN both 0) is active, outFull is held at 0. A core write during the read changes busDout at the next edge but leaves outFull at 0. After the read, outFull stays 0 until a later core write.
- R8: When either csN or rdN returns high after a read, busOe drops at once. irqFlag goes to 1 on the third rising edge after the release.
- R9: While portEn is 0, inFull and outFull are 0 one edge later and stay 0. ovf keeps its value. Strobe activity neither changes the input latch nor sets irqFlag.
- R10: irqFlag is cleared only by a coreIrqClr pulse, and a transaction end in the same cycle wins over the clear. irqReq equals irqFlag AND irqEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| portEn | input | 1 | Port-mode enable |
| irqEn | input | 1 | Interrupt request mask |
| coreWrOut | input | 1 | Core write pulse for the output latch |
| coreWrData | input | DATA_W | Byte for the output latch |
| coreRdIn | input | 1 | Core read pulse for the input latch; clears inFull |
| coreOvfClr | input | 1 | Core pulse clearing ovf |
| coreIrqClr | input | 1 | Core pulse clearing irqFlag |
| coreRdData | output | DATA_W | Input latch contents |
| inFull | output | 1 | Input latch holds unread data |
| outFull | output | 1 | Output latch holds data not yet read externally |
| ovf | output | 1 | Input overflow |
| irqFlag | output | 1 | Transaction-complete flag |
| irqReq | output | 1 | Masked interrupt request |
| csN | input | 1 | External select, active low |
| rdN | input | 1 | External read strobe, active low |
| wrN | input | 1 | External write strobe, active low |
| busDin | input | DATA_W | Pin data driven by the master |
| busDout | output | DATA_W | Pin data driven by the block |
| busOe | output | 1 | Pin output enable |

## Verification
The bench uses the default build: an 8-bit data path and two synchronizer stages. With these values, every possible input byte can go through a full external write, and releases alternate between the select and the write strobe. The short synchronizer also makes the three-edge flag latency easy to pin down exactly, both before and at the edge where the flags rise. Read transactions sweep a spread of output bytes and include core writes during the read. Separate passes cover overflow, disabled mode, interrupt masking and a clear arriving in the same cycle as a new flag.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef struct packed {
    logic loadShadow;
    logic commitIn;
    logic loadOut;
  } strobe_t;
endpackage

// File: rtl/bsp_ctrl.sv
module bsp_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             portEn,
  input  logic             irqEn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic             coreWrOut,
  input  logic             coreRdIn,
  input  logic             coreOvfClr,
  input  logic             coreIrqClr,
  output bsp_pkg::strobe_t stb,
  output logic             inFull,
  output logic             outFull,
  output logic             ovf,
  output logic             irqFlag,
  output logic             irqReq
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] wrPipe, rdPipe;
  logic wrS, rdS, wrPrev, rdPrev, wrEnd, rdEnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPipe <= '0;
      rdPipe <= '0;
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPipe <= {wrPipe[TOP-1:0], ~csN & ~wrN};
      rdPipe <= {rdPipe[TOP-1:0], ~csN & ~rdN};
      wrPrev <= wrS;
      rdPrev <= rdS;
    end
  end

  assign wrS   = wrPipe[TOP] & portEn;
  assign rdS   = rdPipe[TOP] & portEn;
  assign wrEnd = wrPrev & ~wrS & portEn;
  assign rdEnd = rdPrev & ~rdS & portEn;

  assign stb.loadShadow = wrS;
  assign stb.commitIn   = wrEnd;
  assign stb.loadOut    = coreWrOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inFull  <= 1'b0;
      outFull <= 1'b0;
      ovf     <= 1'b0;
      irqFlag <= 1'b0;
    end else begin
      if (!portEn)        inFull <= 1'b0;
      else if (wrEnd)     inFull <= 1'b1;
      else if (coreRdIn)  inFull <= 1'b0;

      if (!portEn)        outFull <= 1'b0;
      else if (rdS)       outFull <= 1'b0;
      else if (coreWrOut) outFull <= 1'b1;

      if (wrEnd && inFull) ovf <= 1'b1;
      else if (coreOvfClr) ovf <= 1'b0;

      if (wrEnd || rdEnd)  irqFlag <= 1'b1;
      else if (coreIrqClr) irqFlag <= 1'b0;
    end
  end

  assign irqReq = irqFlag & irqEn;

  p_ovf_needs_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(inFull));
  p_idle_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !portEn |=> (!inFull && !outFull));
  p_read_holds_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdS |=> !outFull);
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irqFlag && !coreIrqClr) |=> irqFlag);
endmodule

// File: rtl/bsp_data.sv
module bsp_data #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bsp_pkg::strobe_t  stb,
  input  logic [DATA_W-1:0] busDin,
  input  logic [DATA_W-1:0] coreWrData,
  output logic [DATA_W-1:0] inLatch,
  output logic [DATA_W-1:0] outLatch
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [DATA_W-1:0] dPipe [SYNC_STAGES];
  logic [DATA_W-1:0] shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) dPipe[k] <= '0;
      shadow   <= '0;
      inLatch  <= '0;
      outLatch <= '0;
    end else begin
      dPipe[0] <= busDin;
      for (int k = 1; k < SYNC_STAGES; k++) dPipe[k] <= dPipe[k-1];
      if (stb.loadShadow) shadow   <= dPipe[TOP];
      if (stb.commitIn)   inLatch  <= shadow;
      if (stb.loadOut)    outLatch <= coreWrData;
    end
  end

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.commitIn |=> $stable(inLatch));
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.loadOut |=> $stable(outLatch));
endmodule

// File: rtl/byte_slave_port.sv
module byte_slave_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              portEn,
  input  logic              irqEn,
  input  logic              coreWrOut,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic              coreRdIn,
  input  logic              coreOvfClr,
  input  logic              coreIrqClr,
  output logic [DATA_W-1:0] coreRdData,
  output logic              inFull,
  output logic              outFull,
  output logic              ovf,
  output logic              irqFlag,
  output logic              irqReq,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busDin,
  output logic [DATA_W-1:0] busDout,
  output logic              busOe
);
  bsp_pkg::strobe_t stb;

  bsp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .portEn(portEn), .irqEn(irqEn),
    .csN(csN), .rdN(rdN), .wrN(wrN),
    .coreWrOut(coreWrOut), .coreRdIn(coreRdIn),
    .coreOvfClr(coreOvfClr), .coreIrqClr(coreIrqClr),
    .stb(stb), .inFull(inFull), .outFull(outFull), .ovf(ovf),
    .irqFlag(irqFlag), .irqReq(irqReq)
  );

  bsp_data #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busDin(busDin),
    .coreWrData(coreWrData), .inLatch(coreRdData), .outLatch(busDout)
  );

  assign busOe = portEn & ~csN & ~rdN;
endmodule

// File: tb/byte_slave_port_test.sv
module byte_slave_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic portEn = 1'b0, irqEn = 1'b0;
  logic coreWrOut = 1'b0, coreRdIn = 1'b0, coreOvfClr = 1'b0, coreIrqClr = 1'b0;
  logic [7:0] coreWrData = '0, busDin = '0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] coreRdData, busDout;
  logic inFull, outFull, ovf, irqFlag, irqReq, busOe;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  byte_slave_port uut (
    .clk(clk), .rst_n(rst_n), .portEn(portEn), .irqEn(irqEn),
    .coreWrOut(coreWrOut), .coreWrData(coreWrData), .coreRdIn(coreRdIn),
    .coreOvfClr(coreOvfClr), .coreIrqClr(coreIrqClr), .coreRdData(coreRdData),
    .inFull(inFull), .outFull(outFull), .ovf(ovf), .irqFlag(irqFlag),
    .irqReq(irqReq), .csN(csN), .rdN(rdN), .wrN(wrN), .busDin(busDin),
    .busDout(busDout), .busOe(busOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; tick(); sig = 1'b0;
  endtask

  task automatic coreWrite(input logic [7:0] v);
    coreWrData = v; pulse(coreWrOut);
  endtask

  // external write; releases via csN or wrN; checks capture latency
  task automatic extWrite(input logic [7:0] d, input bit viaCs, input logic expPrevFull);
    busDin = d; csN = 1'b0; wrN = 1'b0;
    repeat (3) tick();
    if (viaCs) csN = 1'b1; else wrN = 1'b1;
    busDin = ~d;
    tick(); tick();
    if (portEn) chk("R3 latency inFull", inFull, expPrevFull);
    tick();
    csN = 1'b1; wrN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    @(negedge clk); tick();
    chk("R1 inFull", inFull, 0);  chk("R1 outFull", outFull, 0);
    chk("R1 ovf", ovf, 0);        chk("R1 irqFlag", irqFlag, 0);
    chk("R1 irqReq", irqReq, 0);  chk("R1 busOe", busOe, 0);
    rst_n = 1'b1; portEn = 1'b1; irqEn = 1'b1;
    tick();

    // R3 sweep over every byte value
    for (int i = 0; i < 256; i++) begin
      extWrite(i[7:0], i[0], 1'b0);
      chk("R3 data", coreRdData, i);
      chk("R3 inFull", inFull, 1);
      chk("R3 irqFlag", irqFlag, 1);
      chk("R10 irqReq", irqReq, 1);
      chk("R4 no ovf", ovf, 0);
      coreRdIn = 1'b1; coreIrqClr = 1'b1; tick(); coreRdIn = 1'b0; coreIrqClr = 1'b0;
      chk("R5 inFull cleared", inFull, 0);
      chk("R10 irq cleared", irqFlag, 0);
    end

    // R4 overflow, R5 clear rules
    extWrite(8'h3C, 1'b1, 1'b0);
    extWrite(8'hA5, 1'b0, 1'b1);
    chk("R4 ovf set", ovf, 1);
    chk("R4 overwrite", coreRdData, 8'hA5);
    pulse(coreRdIn);
    chk("R5 inFull cleared", inFull, 0);
    chk("R5 ovf kept after read", ovf, 1);

    // R9 disabled mode, ovf still 1
    coreWrite(8'h11);
    chk("R6 outFull set", outFull, 1);
    chk("R6 busDout", busDout, 8'h11);
    pulse(coreIrqClr);
    portEn = 1'b0; tick();
    chk("R9 outFull forced", outFull, 0);
    chk("R9 ovf kept", ovf, 1);
    csN = 1'b0; rdN = 1'b0; #1;
    chk("R2 busOe off when disabled", busOe, 0);
    csN = 1'b1; rdN = 1'b1;
    extWrite(8'h77, 1'b1, 1'b0);
    repeat (3) tick();
    chk("R9 latch unchanged", coreRdData, 8'hA5);
    chk("R9 no inFull", inFull, 0);
    chk("R9 no irq", irqFlag, 0);
    portEn = 1'b1; tick();
    pulse(coreOvfClr);
    chk("R5 ovf cleared", ovf, 0);

    // R2 R7 R8 read sweep
    for (int v = 0; v < 256; v += 17) begin
      coreWrite(v[7:0]);
      chk("R6 outFull", outFull, 1);
      csN = 1'b0; rdN = 1'b0; #1;
      chk("R2 busOe on", busOe, 1);
      chk("R2 busDout", busDout, v);
      tick(); tick(); tick();
      chk("R7 outFull cleared", outFull, 0);
      coreWrite(~v[7:0]);
      chk("R7 new data on pins", busDout, {24'h0, ~v[7:0]});
      tick();
      chk("R7 outFull stays clear", outFull, 0);
      if (v[0]) csN = 1'b1; else rdN = 1'b1;
      #1;
      chk("R8 busOe off", busOe, 0);
      tick(); tick();
      chk("R8 irq not yet", irqFlag, 0);
      tick();
      chk("R8 irq set", irqFlag, 1);
      chk("R7 outFull after read", outFull, 0);
      csN = 1'b1; rdN = 1'b1;
      pulse(coreIrqClr);
    end

    // R10 masking and set-wins
    irqEn = 1'b0;
    csN = 1'b0; rdN = 1'b0; repeat (3) tick();
    rdN = 1'b1; tick(); tick();
    coreIrqClr = 1'b1; tick(); coreIrqClr = 1'b0;
    chk("R10 set wins over clear", irqFlag, 1);
    chk("R10 masked irqReq", irqReq, 0);
    irqEn = 1'b1; #1;
    chk("R10 unmasked irqReq", irqReq, 1);
    csN = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule